// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a set of interrupt request lines and the system's message-signalled interrupt path. Each input pin has a pending-request bit, a remote-pending bit and a 64-bit redirection entry. The entry gives the vector, delivery mode, destination, destination mode, trigger mode and mask. When a pin has an unmasked request, the engine turns that entry into one 32-bit address / 32-bit data message and offers it on a valid/ready output.

Request line changes arrive as single-cycle events. Each event carries a line number and a level. A separate register block writes the redirection entries through a simple write strobe. A separate end-of-interrupt block reports vectors that have finished service. Level-triggered pins set remote-pending when they are delivered. They stay silent until an end-of-interrupt names their vector.

The output follows valid/ready rules. A message appears with `msg_valid_o` high and keeps its address and data unchanged until a cycle in which `msg_ready_i` is high. A new message may be loaded in that same cycle. While the consumer holds ready low, pending requests stay in the per-pin state, so no request is lost.

Top module: `irq_route_engine`

## Requirements
- R1: After reset, `msg_valid_o` is low, no pin has a request or remote-pending bit, and every entry reads as edge mode with its mask (bit 16) set. A request event on such a pin therefore yields no message.
- R2: A request event on line 0 acts on pin 2. Lines 1 to PINS-1 act on the pin of the same number. Events on lines PINS and above have no effect.
- R3: On an edge pin (entry bit 15 = 0), an event with level 1 on an unmasked pin latches a request, which is delivered exactly once. An event with level 0 has no effect.
- R4: An edge event on a pin whose mask bit (bit 16) is set is discarded. Clearing the mask later does not produce a message.
- R5: On a level pin (entry bit 15 = 1), an event with level 1 sets the request. Delivery of a level pin sets its remote-pending bit. Further high events yield no message while remote-pending is set.
- R6: On a level pin, an event with level 0 clears the request. A masked level request is held, and it is delivered once the mask is cleared.
- R7: An end-of-interrupt whose vector equals a level pin's entry bits 7:0 clears that pin's remote-pending bit. If the pin's request is still set, the pin is delivered again. A non-matching vector has no effect.
- R8: The message address is 0xFEE00000 ORed with entry bits 63:48 placed at address bits 19:4, and entry bit 11 placed at address bit 2. The message data carries entry bits 7:0 at data bits 7:0, entry bits 10:8 at data bits 10:8, and the trigger bit at data bit 15.
- R9: When several pins are eligible at once, they are delivered in ascending pin order.
- R10: While `msg_valid_o` is high and `msg_ready_i` is low, the valid flag, address and data stay unchanged.
- R11: Entry bit 14 is remote-pending and cannot be written: a table write keeps the current remote-pending value. The exception is a write that selects edge mode, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid_i | input | 1 | Request line event strobe |
| evt_line_i | input | LINE_W | Line number of the event |
| evt_level_i | input | 1 | New level of the line |
| tbl_we_i | input | 1 | Redirection entry write strobe |
| tbl_pin_i | input | PIN_W | Pin whose entry is written |
| tbl_data_i | input | 64 | New entry value |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | Vector that finished service |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Consumer accepts the message |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
A request bit stuck high or cleared at the wrong moment shows up at the port within two cycles of the triggering event. It appears as a duplicate message or as a missing one. A remote-pending bit in the wrong state is hidden until the next high event or end-of-interrupt on that pin. The stimulus therefore repeats events and end-of-interrupts, both matching and non-matching, and counts the messages that follow each one. Mistakes in field placement show up directly in the captured address and data. Mistakes in priority or back-pressure show up as a wrong order or a changed payload while ready is held low.

// File: rtl/ire_pkg.sv
package ire_pkg;
  localparam int ENTRY_W     = 64;
  localparam int VEC_W       = 8;
  localparam int DELIV_LSB   = 8;
  localparam int DELIV_W     = 3;
  localparam int DMODE_BIT   = 11;
  localparam int RPEND_BIT   = 14;
  localparam int TRIG_BIT    = 15;
  localparam int MASK_BIT    = 16;
  localparam int DEST_LSB    = 48;
  localparam int DEST_W      = 16;
  localparam int A_DEST_LSB  = 4;
  localparam int A_DMODE_BIT = 2;
  localparam int D_TRIG_BIT  = 15;
  localparam int D_DELIV_LSB = 8;
  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
  localparam logic [ENTRY_W-1:0] RESET_ENTRY = ENTRY_W'(1) << MASK_BIT;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msi_msg_t;

  function automatic msi_msg_t form_msg(input logic [ENTRY_W-1:0] e);
    msi_msg_t m;
    m.addr = MSG_BASE
           | (32'(e[DEST_LSB +: DEST_W]) << A_DEST_LSB)
           | (32'(e[DMODE_BIT]) << A_DMODE_BIT);
    m.data = 32'(e[VEC_W-1:0])
           | (32'(e[TRIG_BIT]) << D_TRIG_BIT)
           | (32'(e[DELIV_LSB +: DELIV_W]) << D_DELIV_LSB);
    return m;
  endfunction
endpackage

// File: rtl/ire_line_map.sv
module ire_line_map #(
  parameter int PINS       = 24,
  parameter int LINE_W     = 5,
  parameter int STEER_FROM = 0,
  parameter int STEER_TO   = 2
) (
  input  logic              evt_valid,
  input  logic [LINE_W-1:0] evt_line,
  output logic [PINS-1:0]   hit
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    if (p == STEER_TO) begin : g_steer
      assign hit[p] = evt_valid &&
                      (evt_line == LINE_W'(STEER_FROM) || evt_line == LINE_W'(p));
    end else if (p == STEER_FROM) begin : g_unused
      assign hit[p] = 1'b0;
    end else begin : g_direct
      assign hit[p] = evt_valid && (evt_line == LINE_W'(p));
    end
  end
endmodule

// File: rtl/ire_pin_slot.sv
module ire_pin_slot
  import ire_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               evt_hit,
  input  logic               evt_level,
  input  logic               eoi_valid,
  input  logic [VEC_W-1:0]   eoi_vector,
  input  logic               grant,
  output logic [ENTRY_W-1:0] entry_o,
  output logic               want_o
);
  logic [ENTRY_W-1:0] entry, entry_n;
  logic req, req_n, rpend, rpend_n;
  logic is_level, masked, eoi_hit;

  assign is_level = entry[TRIG_BIT];
  assign masked   = entry[MASK_BIT];
  assign eoi_hit  = eoi_valid && is_level && (entry[VEC_W-1:0] == eoi_vector);
  assign want_o   = req && !masked && (!is_level || !rpend);
  assign entry_o  = entry;

  always_comb begin
    req_n = req;
    if (grant && !is_level) req_n = 1'b0;
    if (evt_hit) begin
      if (is_level)                 req_n = evt_level;
      else if (evt_level && !masked) req_n = 1'b1;
    end
    rpend_n = (rpend && !eoi_hit) || (grant && is_level);
    if (wr_en && !wr_data[TRIG_BIT]) rpend_n = 1'b0;
    entry_n = entry;
    if (wr_en) begin
      entry_n = wr_data;
      entry_n[RPEND_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry <= RESET_ENTRY;
      req   <= 1'b0;
      rpend <= 1'b0;
    end else begin
      entry <= entry_n;
      req   <= req_n;
      rpend <= rpend_n;
    end
  end

  // R4
  masked_edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hit && !is_level && masked && !req |=> !req);
  // R5
  level_no_redeliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !(is_level && rpend));
  // R5
  level_rpend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant && is_level && !wr_en |=> rpend);
  // R11
  edge_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[TRIG_BIT] |=> !rpend);
endmodule

// File: rtl/ire_pick.sv
module ire_pick #(
  parameter int N    = 24,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    want,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) idx = IDXW'(i);
    end
  end
  assign any = |want;
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
  import ire_pkg::*;
#(
  parameter int PINS   = 24,
  parameter int LINE_W = 5,
  parameter int PIN_W  = $clog2(PINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid_i,
  input  logic [LINE_W-1:0]  evt_line_i,
  input  logic               evt_level_i,
  input  logic               tbl_we_i,
  input  logic [PIN_W-1:0]   tbl_pin_i,
  input  logic [ENTRY_W-1:0] tbl_data_i,
  input  logic               eoi_valid_i,
  input  logic [VEC_W-1:0]   eoi_vector_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [31:0]        msg_addr_o,
  output logic [31:0]        msg_data_o
);
  logic [PINS-1:0]    hit, want, grant;
  logic [ENTRY_W-1:0] entries [PINS];
  logic               any, take;
  logic [PIN_W-1:0]   pick_idx;
  msi_msg_t           next_msg;

  ire_line_map #(.PINS(PINS), .LINE_W(LINE_W)) u_map (
    .evt_valid(evt_valid_i), .evt_line(evt_line_i), .hit(hit));

  for (genvar p = 0; p < PINS; p++) begin : g_slot
    ire_pin_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_we_i && tbl_pin_i == PIN_W'(p)), .wr_data(tbl_data_i),
      .evt_hit(hit[p]), .evt_level(evt_level_i),
      .eoi_valid(eoi_valid_i), .eoi_vector(eoi_vector_i),
      .grant(grant[p]), .entry_o(entries[p]), .want_o(want[p]));
  end

  ire_pick #(.N(PINS), .IDXW(PIN_W)) u_pick (.want(want), .any(any), .idx(pick_idx));

  assign take     = any && (!msg_valid_o || msg_ready_i);
  assign grant    = take ? (PINS'(1) << pick_idx) : '0;
  assign next_msg = form_msg(entries[pick_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid_o <= 1'b0;
      msg_addr_o  <= '0;
      msg_data_o  <= '0;
    end else if (take) begin
      msg_valid_o <= 1'b1;
      msg_addr_o  <= next_msg.addr;
      msg_data_o  <= next_msg.data;
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  // R10
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o));
  // R9
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R1
  no_msg_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !msg_valid_o);
endmodule

// File: tb/irq_route_engine_tb.sv
`timescale 1ns/1ps
module irq_route_engine_tb;
  localparam int PINS = 24, LINE_W = 5, PIN_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 0, evt_level = 0, tbl_we = 0, eoi_valid = 0, msg_ready = 1;
  logic [LINE_W-1:0] evt_line = '0;
  logic [PIN_W-1:0]  tbl_pin = '0;
  logic [63:0]       tbl_data = '0;
  logic [7:0]        eoi_vector = '0;
  logic              msg_valid;
  logic [31:0]       msg_addr, msg_data;

  int checks = 0, failures = 0, n_msg = 0;
  bit done = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];

  always #2.5 clk = ~clk;

  irq_route_engine #(.PINS(PINS), .LINE_W(LINE_W), .PIN_W(PIN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid_i(evt_valid), .evt_line_i(evt_line),
    .evt_level_i(evt_level), .tbl_we_i(tbl_we), .tbl_pin_i(tbl_pin),
    .tbl_data_i(tbl_data), .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data));

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && n_msg < 64) begin
      log_addr[n_msg] = msg_addr;
      log_data[n_msg] = msg_data;
      n_msg++;
    end
  end

  // line, level, expect a message, expected vector
  localparam logic [14:0] VECS [8] = '{
    {5'd3,  1'b1, 1'b1, 8'h43},
    {5'd0,  1'b1, 1'b1, 8'h42},
    {5'd2,  1'b1, 1'b1, 8'h42},
    {5'd23, 1'b1, 1'b1, 8'h57},
    {5'd24, 1'b1, 1'b0, 8'h00},
    {5'd31, 1'b1, 1'b0, 8'h00},
    {5'd5,  1'b0, 1'b0, 8'h00},
    {5'd1,  1'b1, 1'b1, 8'h41}
  };

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic lvl, input logic msk,
                                     input logic [2:0] dlv, input logic dm, input logic [15:0] dst);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dlv; e[11] = dm; e[15] = lvl; e[16] = msk; e[63:48] = dst;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input int line, input logic lvl);
    @(posedge clk); #1;
    evt_valid = 1; evt_line = LINE_W'(line); evt_level = lvl;
    @(posedge clk); #1;
    evt_valid = 0;
  endtask

  task automatic wr(input int pin, input logic [63:0] d);
    @(posedge clk); #1;
    tbl_we = 1; tbl_pin = PIN_W'(pin); tbl_data = d;
    @(posedge clk); #1;
    tbl_we = 0;
  endtask

  task automatic eoi(input logic [7:0] v);
    @(posedge clk); #1;
    eoi_valid = 1; eoi_vector = v;
    @(posedge clk); #1;
    eoi_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    settle(3);
    rst_n = 1;
    settle(1);
    check("R1 valid after reset", 32'(msg_valid), 32'd0);
    fire(4, 1); settle(4);
    check("R1 reset entry masked", n_msg, 0);
    wr(4, mk(8'h44, 0, 0, 0, 0, 16'd4)); settle(4);
    check("R4 masked edge discarded", n_msg, 0);

    for (int p = 0; p < PINS; p++) wr(p, mk(8'h40 + 8'(p), 0, 0, 0, 0, 16'(p)));
    settle(4);

    for (int i = 0; i < 8; i++) begin
      base = n_msg;
      fire(int'(VECS[i][14:10]), VECS[i][9]);
      settle(4);
      check("R2/R3 table count", n_msg - base, 32'(VECS[i][8]));
      if (VECS[i][8]) check("R2/R3 table vector", 32'(log_data[base][7:0]), 32'(VECS[i][7:0]));
    end
    check("R8 edge address", log_addr[0], 32'hFEE0_0030);

    // R9 and R10: ordering and back-pressure
    base = n_msg;
    msg_ready = 0;
    fire(12, 1); fire(9, 1); fire(7, 1); settle(2);
    check("R10 valid held", 32'(msg_valid), 32'd1);
    check("R10 data held", msg_data, 32'h0000_004C);
    settle(3);
    check("R10 data stable", msg_data, 32'h0000_004C);
    msg_ready = 1; settle(6);
    check("R9 count", n_msg - base, 3);
    check("R9 first", log_data[base], 32'h4C);
    check("R9 second", log_data[base+1], 32'h47);
    check("R9 third", log_data[base+2], 32'h49);

    // R5, R7, R6: level pin 10
    wr(10, mk(8'h60, 1, 0, 0, 0, 16'd10)); settle(2);
    base = n_msg; fire(10, 1); settle(4);
    check("R5 level delivered", n_msg - base, 1);
    check("R8 level data", log_data[base], 32'h0000_8060);
    check("R8 level addr", log_addr[base], 32'hFEE0_00A0);
    base = n_msg; fire(10, 1); settle(4);
    check("R5 coalesced", n_msg - base, 0);
    base = n_msg; eoi(8'h61); settle(4);
    check("R7 other vector", n_msg - base, 0);
    base = n_msg; eoi(8'h60); settle(4);
    check("R7 redelivered", n_msg - base, 1);
    base = n_msg; fire(10, 0); eoi(8'h60); settle(4);
    check("R6 low cleared", n_msg - base, 0);
    base = n_msg; fire(10, 1); settle(4);
    check("R5 after clear", n_msg - base, 1);

    // R11: remote-pending read-only, edge write clears it
    base = n_msg; wr(10, mk(8'h60, 1, 0, 0, 0, 16'd10)); fire(10, 1); settle(4);
    check("R11 write keeps remote", n_msg - base, 0);
    base = n_msg;
    wr(10, mk(8'h60, 0, 1, 0, 0, 16'd10));
    wr(10, mk(8'h60, 1, 1, 0, 0, 16'd10));
    wr(10, mk(8'h60, 1, 0, 0, 0, 16'd10)); settle(4);
    check("R11 edge write cleared remote", n_msg - base, 1);
    base = n_msg; wr(13, mk(8'h6D, 1, 0, 0, 0, 16'd13) | (64'd1 << 14)); fire(13, 1); settle(4);
    check("R11 remote not writable", n_msg - base, 1);

    // R6: masked level request held
    wr(11, mk(8'h6B, 1, 1, 0, 0, 16'd11));
    base = n_msg; fire(11, 1); settle(4);
    check("R6 masked level held", n_msg - base, 0);
    wr(11, mk(8'h6B, 1, 0, 0, 0, 16'd11)); settle(4);
    check("R6 unmask delivers", n_msg - base, 1);

    // R8: full field placement
    wr(20, mk(8'h9A, 0, 0, 3'b101, 1, 16'hBEEF));
    base = n_msg; fire(20, 1); settle(4);
    check("R8 count", n_msg - base, 1);
    check("R8 addr", log_addr[base], 32'hFEEB_EEF4);
    check("R8 data", log_data[base], 32'h0000_059A);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule